// File: doc/BRIEF.md
# Bridge Overcurrent Retry Fault Manager

This block is the protection controller for a pair of H-bridges. Each bridge has its own synchronised overcurrent flag. A bridge is shut down only after its flag has stayed high without a break for a programmable number of clock cycles. The bridge is then held off for a long, fixed retry interval, and after that it is released automatically. If the short circuit is still there when the bridge is released, a fresh qualification starts and the cycle repeats.

Two flags act on the whole chip. Over-temperature switches every bridge off for as long as it is present and gives control back as soon as it drops. Undervoltage also switches every bridge off, and it wipes all qualification progress and any pending retry wait.

An active-low fault output goes low whenever at least one bridge is in its retry wait, or when either chip-wide flag is active. Both timing windows are given as cycle counts. The defaults correspond to about 2.7 µs and 1.6 ms at 200 MHz.

Top module: `bridge_fault_mgr`

## Requirements
- R1: After reset is released with all flags low, every bit of bridge_off_o is 0 and fault_no is 1.
- R2: An overcurrent flag that is high for fewer than DEGLITCH_CYC consecutive rising clock edges causes no shutdown. When it drops, its qualification count restarts from zero.
- R3: An overcurrent flag sampled high on DEGLITCH_CYC consecutive edges sets that bridge's bit of bridge_off_o and pulls fault_no low, starting right after the qualifying edge.
- R4: A qualified overcurrent on one bridge leaves the bit of bridge_off_o for the other bridge unchanged. That other bridge goes on qualifying its own flag independently.
- R5: A bridge shut down by overcurrent stays off for exactly RETRY_CYC cycles and is then released. fault_no returns high at release if no other cause is active.
- R6: During the retry wait the bridge's overcurrent flag is ignored. After release a persistent flag needs a full new DEGLITCH_CYC window before the next shutdown.
- R7: While ot_i is high, all bits of bridge_off_o are 1 and fault_no is 0, within the same cycle. Overcurrent cycles seen during that time do not count toward qualification. Operation resumes in the cycle ot_i falls.
- R8: While uv_i is high, all bits of bridge_off_o are 1 and fault_no is 0. Each edge with uv_i high clears every retry wait and every qualification count.
- R9: fault_no is 0 exactly when some bridge is in its retry wait, or ot_i or uv_i is high. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| oc_i | input | NUM_BRIDGES | Per-bridge synchronised overcurrent flag, bit b belongs to bridge b |
| ot_i | input | 1 | Chip over-temperature flag (hysteresis applied upstream) |
| uv_i | input | 1 | Chip undervoltage flag |
| bridge_off_o | output | NUM_BRIDGES | 1 = all switches of bridge b forced off |
| fault_no | output | 1 | Active-low fault indication |

## Verification
A qualification counter that is off by one shows up at the ports as a shutdown one edge early or one edge late, at the end of a sweep of pulse lengths around DEGLITCH_CYC. A retry counter that is off by one moves the release edge, and the bench sees this RETRY_CYC cycles after the trip. State that leaks between bridges, or a clear missed on undervoltage or over-temperature, shows on bridge_off_o or fault_no within one cycle of the next directed phase. The bench compares both outputs on every cycle against an arithmetic model, so any such error is caught in the first cycle where it becomes visible.

// File: rtl/bfm_pkg.sv
package bfm_pkg;
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/bfm_deglitch.sv
module bfm_deglitch #(
  parameter int unsigned DEGLITCH_CYC = 540
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic en_i,
  input  logic flag_i,
  output logic qual_o
);
  localparam int unsigned W = bfm_pkg::cnt_width(DEGLITCH_CYC);
  localparam logic [W-1:0] LAST = W'(DEGLITCH_CYC - 1);

  logic [W-1:0] cnt_q;

  assign qual_o = en_i & flag_i & ~clear_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  cnt_q <= '0;
    else if (clear_i || !en_i || !flag_i || qual_o) cnt_q <= '0;
    else                                          cnt_q <= cnt_q + W'(1);
  end

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/bfm_retry_timer.sv
module bfm_retry_timer #(
  parameter int unsigned RETRY_CYC = 320000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned W = bfm_pkg::cnt_width(RETRY_CYC);
  localparam logic [W-1:0] LAST = W'(RETRY_CYC - 1);

  logic         busy_q;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clear_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + W'(1);
      end
    end
  end

  assign busy_o = busy_q;

  p_uv_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !busy_o);
  p_hold_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !clear_i && cnt_q != LAST) |=> busy_q);
  p_start_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
endmodule

// File: rtl/bfm_channel.sv
module bfm_channel #(
  parameter int unsigned DEGLITCH_CYC = 540,
  parameter int unsigned RETRY_CYC    = 320000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oc_i,
  input  logic ot_i,
  input  logic uv_i,
  output logic hold_o
);
  logic qual, hold;

  // counting only while bridge is allowed to conduct
  bfm_deglitch #(.DEGLITCH_CYC(DEGLITCH_CYC)) u_dg (
    .clk_i, .rst_ni, .clear_i(uv_i), .en_i(~hold & ~ot_i),
    .flag_i(oc_i), .qual_o(qual)
  );

  bfm_retry_timer #(.RETRY_CYC(RETRY_CYC)) u_rt (
    .clk_i, .rst_ni, .clear_i(uv_i), .start_i(qual), .busy_o(hold)
  );

  assign hold_o = hold;

  p_ot_no_trip_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_i |-> !qual);
endmodule

// File: rtl/bridge_fault_mgr.sv
module bridge_fault_mgr #(
  parameter int unsigned NUM_BRIDGES  = 2,
  parameter int unsigned DEGLITCH_CYC = 540,
  parameter int unsigned RETRY_CYC    = 320000
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_BRIDGES-1:0] oc_i,
  input  logic                   ot_i,
  input  logic                   uv_i,
  output logic [NUM_BRIDGES-1:0] bridge_off_o,
  output logic                   fault_no
);
  logic [NUM_BRIDGES-1:0] hold;
  logic                   chip_off;

  for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_br
    bfm_channel #(.DEGLITCH_CYC(DEGLITCH_CYC), .RETRY_CYC(RETRY_CYC)) u_ch (
      .clk_i, .rst_ni, .oc_i(oc_i[b]), .ot_i, .uv_i, .hold_o(hold[b])
    );
  end

  assign chip_off     = ot_i | uv_i;
  assign bridge_off_o = hold | {NUM_BRIDGES{chip_off}};
  assign fault_no     = ~(|hold | chip_off);

  p_off_faults_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|bridge_off_o) |-> !fault_no);
  p_uv_all_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |-> (&bridge_off_o));
endmodule

// File: tb/bridge_fault_mgr_tb_top.sv
`timescale 1ns/1ps
module bridge_fault_mgr_tb_top;
  localparam int NB = 2;
  localparam int DG = 4;
  localparam int RT = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB-1:0] oc = '0;
  logic          ot = 1'b0, uv = 1'b0;
  logic [NB-1:0] off;
  logic          fault_n;

  int    n_chk = 0, n_bad = 0;
  bit    done = 0;
  string tag = "R1";

  int run_len [NB];
  int hold_left [NB];

  always #2.5 clk = ~clk;

  bridge_fault_mgr #(.NUM_BRIDGES(NB), .DEGLITCH_CYC(DG), .RETRY_CYC(RT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .oc_i(oc), .ot_i(ot), .uv_i(uv),
    .bridge_off_o(off), .fault_no(fault_n)
  );

  // requirement model: consecutive-high length and remaining wait per bridge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin run_len[b] = 0; hold_left[b] = 0; end
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (uv) begin
          run_len[b] = 0; hold_left[b] = 0;
        end else if (hold_left[b] > 0) begin
          hold_left[b] = hold_left[b] - 1; run_len[b] = 0;
        end else if (ot || !oc[b]) begin
          run_len[b] = 0;
        end else if (run_len[b] + 1 == DG) begin
          hold_left[b] = RT; run_len[b] = 0;
        end else begin
          run_len[b] = run_len[b] + 1;
        end
      end
    end
  end

  task automatic check();
    logic [NB-1:0] e_off;
    logic          e_f;
    bit            any_hold = 0;
    for (int b = 0; b < NB; b++) begin
      e_off[b] = (hold_left[b] > 0) || ot || uv;
      if (hold_left[b] > 0) any_hold = 1;
    end
    e_f = !(any_hold || ot || uv);
    n_chk++;
    if (off !== e_off || fault_n !== e_f) begin
      n_bad++;
      $display("FAIL %s t=%0t bridge_off=%b exp=%b fault_n=%b exp=%b",
               tag, $time, off, e_off, fault_n, e_f);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check();
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tag = "R1"; step(3);
    rst_n = 1'b1; step(3);

    tag = "R2";
    for (int len = 1; len < DG; len++)
      for (int b = 0; b < NB; b++) begin
        oc[b] = 1'b1; step(len); oc[b] = 1'b0; step(2);
      end
    oc[0] = 1'b1; step(DG - 1); oc[0] = 1'b0; step(1);
    oc[0] = 1'b1; step(DG - 1); oc[0] = 1'b0; step(2);

    tag = "R3"; oc = 2'b01; step(DG);
    tag = "R4"; oc = 2'b10; step(DG - 1); oc = 2'b00; step(1);
    tag = "R5"; step(RT + 3);

    tag = "R4"; oc = 2'b01; step(DG); oc = 2'b11; step(DG + 2); oc = 2'b00; step(RT + 2);

    tag = "R6"; oc = 2'b10; step(3 * (DG + RT) + 1); oc = 2'b00; step(RT + 2);

    tag = "R7"; ot = 1'b1; oc = 2'b11; step(DG + 3);
    ot = 1'b0; oc = 2'b00; step(2);
    oc = 2'b01; step(DG - 2); ot = 1'b1; step(1); ot = 1'b0; step(DG - 1); oc = 2'b00; step(2);
    oc = 2'b01; step(DG); oc = 2'b00; ot = 1'b1; step(3); ot = 1'b0; step(RT + 2);

    tag = "R8"; oc = 2'b11; step(DG); oc = 2'b00; step(2);
    uv = 1'b1; step(3); uv = 1'b0; step(3);
    oc = 2'b01; step(DG - 1); uv = 1'b1; step(1); uv = 1'b0; step(1); oc = 2'b00; step(2);

    tag = "R9";
    for (int i = 0; i < 2500; i++) begin
      oc[0] = ((i / 3) % 5) != 0;
      oc[1] = ((i / 7) % 3) != 0;
      ot    = (i % 97) >= 90;
      uv    = (i % 211) >= 205;
      step(1);
    end
    oc = '0; ot = 1'b0; uv = 1'b0; step(RT + 2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule